// File: doc/BRIEF.md
# Four-Mode Universal Shift Register

This block is an N-bit register (4 bits by default) whose next state, on every rising clock edge, is picked by a two-bit mode code. The four modes are: keep the stored word, shift one place toward the high index, shift one place toward the low index, or take a whole word from the parallel data input. Each shift direction has its own serial fill input. The bit entering at index 0 comes from `fill_lo`, and the bit entering at index N-1 comes from `fill_hi`. The register can therefore act as a serial-to-parallel converter, as a parallel-to-serial converter, or as a delay line running in either direction. Wide shifters can be built by chaining the end bits of one instance into the fill inputs of the next.

An active-low clear input forces the whole word to zero. The clear acts at once, without waiting for a clock edge, and it overrides every mode. All stored bits share the one clock. Index 0 is the first stage of the register and index N-1 is the last.

Top module: `univ_shift_reg`

## Requirements
- R1: The mode code selects exactly one action per edge: 2'b00 keep, 2'b01 shift toward high index, 2'b10 shift toward low index, 2'b11 parallel load.
- R2: With mode 2'b00, `q` after the edge equals `q` before it.
- R3: With mode 2'b01, bit i takes the old bit i-1 for i from 1 to N-1, and bit 0 takes `fill_lo`, so the word moves exactly one place per edge.
- R4: With mode 2'b10, bit i takes the old bit i+1 for i from 0 to N-2, and bit N-1 takes `fill_hi`, so the word moves exactly one place per edge.
- R5: With mode 2'b11, `q[i]` takes `par_d[i]` for every i on the edge.
- R6: While `clr_n` is 0, `q` is all zeros. The clear takes effect without a clock edge and overrides every mode, including a load of non-zero data.
- R7: An input that the current mode does not use has no effect on `q`: `fill_hi` in mode 2'b01, `fill_lo` in mode 2'b10, both fill inputs in modes 2'b00 and 2'b11, and `par_d` in every mode except 2'b11.
- R8: Shifts in opposite directions on consecutive edges each move the word by exactly one place, with no lost or repeated bits except the one bit that falls off the end on each shift.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock shared by every bit |
| clr_n | input | 1 | Active-low asynchronous clear, dominant over all modes |
| mode | input | 2 | Action code: 00 keep, 01 shift up, 10 shift down, 11 load |
| fill_lo | input | 1 | Serial bit inserted at index 0 when shifting up |
| fill_hi | input | 1 | Serial bit inserted at index N-1 when shifting down |
| par_d | input | N | Parallel data word for a load |
| q | output | N | Stored word |

## Verification
The asynchronous clear and a clocked action, a load of non-zero data in particular, can fall in the same cycle. The bench provokes this by setting load mode with an all-ones word and then pulling `clr_n` low between edges. It first judges `q` as zero before any edge arrives. It then judges `q` as still zero after an edge that occurs while the clear is held. After the clear is released, the next edge must load normally. Randomized runs also drop the clear at arbitrary points among mixed shifts and loads, and compare the result with the bench's own model.

// File: rtl/ushr_pkg.sv
package ushr_pkg;

  typedef enum logic [1:0] {
    M_KEEP  = 2'b00,
    M_UP    = 2'b01,
    M_DOWN  = 2'b10,
    M_LOAD  = 2'b11
  } ushr_mode_e;

  localparam int unsigned SEL_W    = 4;
  localparam int unsigned SEL_KEEP = 0;
  localparam int unsigned SEL_UP   = 1;
  localparam int unsigned SEL_DOWN = 2;
  localparam int unsigned SEL_LOAD = 3;

  // Per-bit next-state choice from a one-hot action vector.
  function automatic logic pick_bit(input logic [SEL_W-1:0] sel,
                                    input logic keep_b, input logic up_b,
                                    input logic down_b, input logic load_b);
    logic r;
    r = (sel[SEL_KEEP] & keep_b) | (sel[SEL_UP] & up_b) |
        (sel[SEL_DOWN] & down_b) | (sel[SEL_LOAD] & load_b);
    return r;
  endfunction

endpackage

// File: rtl/ushr_mode_dec.sv
module ushr_mode_dec
  import ushr_pkg::*;
(
  input  logic [1:0]       mode,
  output logic [SEL_W-1:0] sel
);

  always_comb begin
    sel = '0;
    case (ushr_mode_e'(mode))
      M_KEEP: sel[SEL_KEEP] = 1'b1;
      M_UP:   sel[SEL_UP]   = 1'b1;
      M_DOWN: sel[SEL_DOWN] = 1'b1;
      M_LOAD: sel[SEL_LOAD] = 1'b1;
      default: sel[SEL_KEEP] = 1'b1;
    endcase
  end

  // R1: exactly one action is chosen for any mode code
  always_comb begin
    if (!$isunknown(mode)) begin
      a_r1_one_action: assert ($countones(sel) == 1);
    end
  end

endmodule

// File: rtl/ushr_next.sv
module ushr_next
  import ushr_pkg::*;
#(
  parameter int unsigned N = 4
) (
  input  logic [SEL_W-1:0] sel,
  input  logic [N-1:0]     cur,
  input  logic             fill_lo,
  input  logic             fill_hi,
  input  logic [N-1:0]     par_d,
  output logic [N-1:0]     nxt
);

  localparam int unsigned TOP = N - 1;

  for (genvar i = 0; i < N; i++) begin : g_bit
    logic from_below;
    logic from_above;
    if (i == 0) begin : g_lo_end
      assign from_below = fill_lo;
    end else begin : g_lo_mid
      assign from_below = cur[i-1];
    end
    if (i == TOP) begin : g_hi_end
      assign from_above = fill_hi;
    end else begin : g_hi_mid
      assign from_above = cur[i+1];
    end
    assign nxt[i] = pick_bit(sel, cur[i], from_below, from_above, par_d[i]);
  end

endmodule

// File: rtl/univ_shift_reg.sv
module univ_shift_reg
  import ushr_pkg::*;
#(
  parameter int unsigned N = 4
) (
  input  logic         clk,
  input  logic         clr_n,
  input  logic [1:0]   mode,
  input  logic         fill_lo,
  input  logic         fill_hi,
  input  logic [N-1:0] par_d,
  output logic [N-1:0] q
);

  localparam int unsigned TOP = N - 1;

  logic [SEL_W-1:0] sel;
  logic [N-1:0]     nxt;

  // Named action events for the checks below
  logic ev_keep, ev_up, ev_down, ev_load;
  assign ev_keep = sel[SEL_KEEP];
  assign ev_up   = sel[SEL_UP];
  assign ev_down = sel[SEL_DOWN];
  assign ev_load = sel[SEL_LOAD];

  ushr_mode_dec u_dec (
    .mode (mode),
    .sel  (sel)
  );

  ushr_next #(.N(N)) u_next (
    .sel     (sel),
    .cur     (q),
    .fill_lo (fill_lo),
    .fill_hi (fill_hi),
    .par_d   (par_d),
    .nxt     (nxt)
  );

  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n) q <= '0;
    else        q <= nxt;
  end

  // R2: keep leaves the word untouched
  a_r2_keep: assert property (@(posedge clk) disable iff (!clr_n)
    ev_keep |=> $stable(q));

  // R3: shift up moves one place, fill_lo enters index 0
  a_r3_shift_up: assert property (@(posedge clk) disable iff (!clr_n)
    ev_up |=> (q[TOP:1] == $past(q[TOP-1:0])) && (q[0] == $past(fill_lo)));

  // R4: shift down moves one place, fill_hi enters index N-1
  a_r4_shift_down: assert property (@(posedge clk) disable iff (!clr_n)
    ev_down |=> (q[TOP-1:0] == $past(q[TOP:1])) && (q[TOP] == $past(fill_hi)));

  // R5: load copies the parallel word
  a_r5_load: assert property (@(posedge clk) disable iff (!clr_n)
    ev_load |=> q == $past(par_d));

  // R6: clear holds the word at zero whatever the mode
  always @(posedge clk) begin
    if (!clr_n) begin
      a_r6_clear: assert (q == '0);
    end
  end

endmodule

// File: tb/univ_shift_reg_test.sv
`timescale 1ns/1ps
module univ_shift_reg_test;

  localparam int unsigned N = 4;

  logic         clk = 1'b0;
  logic         clr_n = 1'b1;
  logic [1:0]   mode = 2'b00;
  logic         fill_lo = 1'b0;
  logic         fill_hi = 1'b0;
  logic [N-1:0] par_d = '0;
  logic [N-1:0] q;

  int checks = 0;
  int errors = 0;
  logic [N-1:0] exp_q = '0;

  always #2 clk = ~clk;

  univ_shift_reg #(.N(N)) uut (
    .clk(clk), .clr_n(clr_n), .mode(mode), .fill_lo(fill_lo),
    .fill_hi(fill_hi), .par_d(par_d), .q(q)
  );

  // Bench model, written from the requirement text
  function automatic logic [N-1:0] model(input logic [N-1:0] cur, input logic [1:0] m,
                                         input logic lo, input logic hi,
                                         input logic [N-1:0] d);
    logic [N-1:0] r;
    r = cur;
    if (m == 2'b01) begin
      for (int i = N - 1; i > 0; i--) r[i] = cur[i-1];
      r[0] = lo;
    end else if (m == 2'b10) begin
      for (int i = 0; i < N - 1; i++) r[i] = cur[i+1];
      r[N-1] = hi;
    end else if (m == 2'b11) begin
      r = d;
    end
    return r;
  endfunction

  task automatic check(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: q=%b expected %b", tag, act, exp);
    end
  endtask

  // Called at a falling edge: drive, cross one rising edge, compare.
  task automatic step(input string tag, input logic [1:0] m, input logic lo,
                      input logic hi, input logic [N-1:0] d);
    mode = m; fill_lo = lo; fill_hi = hi; par_d = d;
    exp_q = model(exp_q, m, lo, hi, d);
    @(posedge clk);
    @(negedge clk);
    check(tag, q, exp_q);
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog: q=%b expected %b", q, exp_q);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    #1 clr_n = 1'b0;
    @(negedge clk);
    check("R6 reset", q, '0);
    clr_n = 1'b1;
    exp_q = '0;

    step("R5 load", 2'b11, 1'b0, 1'b0, 4'b1010);
    step("R2 keep", 2'b00, 1'b1, 1'b1, 4'b0101);
    step("R7 keep ignores fill and data", 2'b00, 1'b0, 1'b1, 4'b1111);
    step("R3 shift up", 2'b01, 1'b1, 1'b0, 4'b0000);
    step("R7 up ignores fill_hi", 2'b01, 1'b0, 1'b1, 4'b1111);
    step("R4 shift down", 2'b10, 1'b0, 1'b1, 4'b0000);
    step("R7 down ignores fill_lo", 2'b10, 1'b1, 1'b0, 4'b1111);
    step("R7 load ignores fills", 2'b11, 1'b1, 1'b1, 4'b0110);
    for (int k = 0; k < 8; k++) begin
      step("R8 alternate up", 2'b01, k[0], ~k[0], 4'b0000);
      step("R8 alternate down", 2'b10, ~k[1], k[0], 4'b1111);
    end
    // full walk of a one through the register in each direction
    step("R5 load zero", 2'b11, 1'b0, 1'b0, 4'b0000);
    step("R3 walk in", 2'b01, 1'b1, 1'b0, 4'b0000);
    for (int k = 0; k < N; k++) step("R3 walk", 2'b01, 1'b0, 1'b0, 4'b0000);
    step("R4 walk in", 2'b10, 1'b0, 1'b1, 4'b0000);
    for (int k = 0; k < N; k++) step("R4 walk", 2'b10, 1'b0, 1'b0, 4'b0000);

    // Clear arriving while a non-zero load is selected
    step("R5 preload", 2'b11, 1'b0, 1'b0, 4'b1001);
    mode = 2'b11; par_d = 4'b1111;
    #1 clr_n = 1'b0;
    #0.5 check("R6 clear without edge", q, '0);
    @(posedge clk);
    @(negedge clk);
    check("R6 clear beats load", q, '0);
    clr_n = 1'b1;
    exp_q = '0;
    step("R6 load after release", 2'b11, 1'b0, 1'b0, 4'b1111);

    // Constrained random traffic with occasional clears
    for (int k = 0; k < 600; k++) begin
      logic [31:0] r;
      r = $urandom();
      if (r[31:27] == 5'd0) begin
        #1 clr_n = 1'b0;
        #0.5 check("R6 random clear", q, '0);
        @(negedge clk);
        clr_n = 1'b1;
        exp_q = '0;
      end else begin
        step("R1 random", r[1:0], r[2], r[3], r[7:4]);
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule